// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block makes a clock-enable tick at a non-integer fraction of its reference clock. It does this by mixing two integer periods. In each pattern it emits a run of periods that are `div_lo` reference cycles long, followed by a run of periods that are `div_hi` cycles long. The run lengths are set by `run_lo` and `run_hi`. The pattern then repeats, so the average period is (div_lo·run_lo + div_hi·run_hi)/(run_lo + run_hi) reference cycles. With a 24 MHz reference, div_lo = 733, div_hi = 732, run_lo = 2 and run_hi = 3 give an average tick rate of about 32768 Hz.

Every period begins with a one-cycle tick. A square-wave output is high for the first half of each period. The divider runs only while the input gate is high. The interleaving of the two periods is used only while the fractional-mode enable is high; when it is low, every period uses `div_lo`. Configuration is captured at pattern boundaries, so a pattern is never built from mixed settings.

Top module: `dmd_clk_div`

## Requirements
- R1: While reset is asserted, `tick_o` and `sq_o` are low.
- R2: While `osc_gate_i` is low, no tick is produced and `sq_o` is low. When the gate is high at a rising clock edge and the divider was idle, `tick_o` is high in the cycle after that edge.
- R3: Each output period lasts exactly N reference cycles, where N is the modulus of the current phase. `tick_o` is high only in the first cycle of the period.
- R4: With fractional mode on, a pattern is `run_lo_i` periods of `div_lo_i` cycles followed by `run_hi_i` periods of `div_hi_i` cycles, and patterns repeat back to back. The widths are 12 bits for the moduli and 8 bits for the run lengths.
- R5: `sq_o` is high for the first floor(N/2) cycles of each period, starting in the tick cycle, and low for the rest of the period.
- R6: Changes to the configuration inputs or to `frac_mode_i` while a pattern runs take effect only at the start of the next pattern.
- R7: A phase whose run length is 0 is skipped, so the pattern consists of the other phase alone.
- R8: With fractional mode on and both run lengths 0, the divider stays idle and produces no ticks. It checks the configuration every cycle and starts, with a tick one cycle later, as soon as a run length becomes nonzero.
- R9: With `frac_mode_i` low, every period is `div_lo_i` cycles long and both run lengths are ignored, including when both are 0.
- R10: A modulus value of 0 or 1 is treated as 2.
- R11: Dropping `osc_gate_i` stops `tick_o` and `sq_o` from the next cycle on. When the gate is raised again, the divider starts over at the beginning of a pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| osc_gate_i | input | 1 | Input gate; the divider runs only while this is high |
| frac_mode_i | input | 1 | 1: interleave two moduli; 0: use `div_lo_i` only |
| div_lo_i | input | 12 | Modulus of the first phase |
| div_hi_i | input | 12 | Modulus of the second phase |
| run_lo_i | input | 8 | Number of periods in the first phase |
| run_hi_i | input | 8 | Number of periods in the second phase |
| tick_o | output | 1 | One-cycle pulse at the start of each period |
| sq_o | output | 1 | Square wave, high for the first half of each period |

## Verification
The assertions take for granted that the inputs are synchronous to `clk_i` and that reset is applied before the gate is first raised. They also rely on the clamping of the moduli, which keeps every period at two cycles or more. That minimum is what makes a tick always one cycle long and puts the square output high in the tick cycle. Any configuration value may arrive at any time, because the phase sequencer captures it only at a pattern boundary or when starting from idle. The stimulus changes every input half a cycle away from the active edge. It includes moduli below 2, zero run lengths and a configuration change in the middle of a pattern, so the clamping and capture paths are exercised.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

    // Which modulus the current output period uses
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } dmd_phase_e;

    // Shortest allowed period, in reference cycles
    localparam int unsigned DMD_MIN_PERIOD = 2;

endpackage

// File: rtl/dmd_cfg_sel.sv
// Turns raw configuration into the settings the sequencer uses:
// clamps the moduli and applies integer mode.
module dmd_cfg_sel #(
    parameter int unsigned NW = 12,
    parameter int unsigned MW = 8
) (
    input  logic                 frac_mode_i,
    input  logic [1:0][NW-1:0]   n_raw_i,
    input  logic [MW-1:0]        m_lo_raw_i,
    input  logic [MW-1:0]        m_hi_raw_i,
    output logic [1:0][NW-1:0]   n_eff_o,
    output logic [MW-1:0]        m_lo_eff_o,
    output logic [MW-1:0]        m_hi_eff_o,
    output logic                 run_o
);
    import dmd_pkg::*;

    localparam logic [NW-1:0] N_FLOOR = NW'(DMD_MIN_PERIOD);
    localparam logic [MW-1:0] M_ONE   = MW'(1);

    // Each modulus gets the same floor clamp
    for (genvar g = 0; g < 2; g++) begin : g_clamp
        always_comb begin
            n_eff_o[g] = (n_raw_i[g] < N_FLOOR) ? N_FLOOR : n_raw_i[g];
        end
    end

    always_comb begin
        if (frac_mode_i) begin
            m_lo_eff_o = m_lo_raw_i;
            m_hi_eff_o = m_hi_raw_i;
        end else begin
            // Integer mode: a one-period pattern of the low-phase modulus
            m_lo_eff_o = M_ONE;
            m_hi_eff_o = '0;
        end
        run_o = (m_lo_eff_o != '0) || (m_hi_eff_o != '0);
    end

endmodule

// File: rtl/dmd_phase_seq.sv
// Steps through the two phases of a pattern and holds the captured
// configuration, which is reloaded only at pattern boundaries.
module dmd_phase_seq #(
    parameter int unsigned NW = 12,
    parameter int unsigned MW = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 gate_i,
    input  logic [1:0][NW-1:0]   n_eff_i,
    input  logic [MW-1:0]        m_lo_eff_i,
    input  logic [MW-1:0]        m_hi_eff_i,
    input  logic                 run_i,
    input  logic                 period_end_i,
    output logic                 active_o,
    output logic [NW-1:0]        cur_n_o
);
    import dmd_pkg::*;

    localparam logic [MW-1:0] M_ONE = MW'(1);

    typedef struct packed {
        logic                active;
        dmd_phase_e          phase;
        logic [MW-1:0]       pcnt;
        logic [1:0][NW-1:0]  n;
        logic [MW-1:0]       m_lo;
        logic [MW-1:0]       m_hi;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic [MW-1:0] cur_m;
    logic          last_in_phase;
    logic          pattern_end;

    always_comb begin
        s_d           = s_q;
        cur_m         = (s_q.phase == PH_HI) ? s_q.m_hi : s_q.m_lo;
        last_in_phase = (s_q.pcnt == cur_m - M_ONE);
        pattern_end   = s_q.active && period_end_i && last_in_phase &&
                        ((s_q.phase == PH_HI) || (s_q.m_hi == '0));

        if (!gate_i) begin
            s_d.active = 1'b0;
            s_d.phase  = PH_LO;
            s_d.pcnt   = '0;
        end else if (!s_q.active || pattern_end) begin
            // Capture a fresh configuration and begin a pattern
            s_d.active = run_i;
            s_d.n      = n_eff_i;
            s_d.m_lo   = m_lo_eff_i;
            s_d.m_hi   = m_hi_eff_i;
            s_d.phase  = (m_lo_eff_i != '0) ? PH_LO : PH_HI;
            s_d.pcnt   = '0;
        end else if (period_end_i) begin
            if (last_in_phase) begin
                s_d.phase = PH_HI;
                s_d.pcnt  = '0;
            end else begin
                s_d.pcnt  = s_q.pcnt + M_ONE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.active;
    assign cur_n_o  = (s_q.phase == PH_HI) ? s_q.n[1] : s_q.n[0];

    // R4: the period count stays within the run length of its phase
    assert_pcnt_in_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.active |-> (s_q.pcnt < cur_m));

    // R7: an active phase never has a run length of zero
    assert_phase_not_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.active |-> (cur_m != '0));

    // R6: the captured configuration holds for the whole pattern
    assert_cfg_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.active && $past(s_q.active) && !$past(pattern_end) && $past(gate_i))
        |-> $stable({s_q.n, s_q.m_lo, s_q.m_hi}));

    // R11: a low gate leaves the divider idle on the next cycle
    assert_gate_low_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gate_i |=> !s_q.active);

endmodule

// File: rtl/dmd_period_ctr.sv
// Counts reference cycles within one output period and forms the tick
// and the square wave.
module dmd_period_ctr #(
    parameter int unsigned NW = 12
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           active_i,
    input  logic [NW-1:0]  n_i,
    output logic           period_end_o,
    output logic           tick_o,
    output logic           sq_o
);
    localparam logic [NW-1:0] N_ONE = NW'(1);

    logic [NW-1:0] cyc_d, cyc_q;

    always_comb begin
        period_end_o = active_i && (cyc_q == n_i - N_ONE);
        if (!active_i || period_end_o) begin
            cyc_d = '0;
        end else begin
            cyc_d = cyc_q + N_ONE;
        end
        tick_o = active_i && (cyc_q == '0);
        sq_o   = active_i && (cyc_q < (n_i >> 1));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_d;
        end
    end

    // R3: the cycle count never reaches the modulus in use
    assert_cyc_in_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_i |-> (cyc_q < n_i));

    // R3: a tick lasts one cycle
    assert_tick_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/dmd_clk_div.sv
module dmd_clk_div #(
    parameter int unsigned NW = 12,
    parameter int unsigned MW = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           osc_gate_i,
    input  logic           frac_mode_i,
    input  logic [NW-1:0]  div_lo_i,
    input  logic [NW-1:0]  div_hi_i,
    input  logic [MW-1:0]  run_lo_i,
    input  logic [MW-1:0]  run_hi_i,
    output logic           tick_o,
    output logic           sq_o
);
    logic [1:0][NW-1:0] n_eff;
    logic [MW-1:0]      m_lo_eff, m_hi_eff;
    logic               run;
    logic               active;
    logic [NW-1:0]      cur_n;
    logic               period_end;

    dmd_cfg_sel #(.NW(NW), .MW(MW)) u_cfg (
        .frac_mode_i (frac_mode_i),
        .n_raw_i     ({div_hi_i, div_lo_i}),
        .m_lo_raw_i  (run_lo_i),
        .m_hi_raw_i  (run_hi_i),
        .n_eff_o     (n_eff),
        .m_lo_eff_o  (m_lo_eff),
        .m_hi_eff_o  (m_hi_eff),
        .run_o       (run)
    );

    dmd_phase_seq #(.NW(NW), .MW(MW)) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .gate_i       (osc_gate_i),
        .n_eff_i      (n_eff),
        .m_lo_eff_i   (m_lo_eff),
        .m_hi_eff_i   (m_hi_eff),
        .run_i        (run),
        .period_end_i (period_end),
        .active_o     (active),
        .cur_n_o      (cur_n)
    );

    dmd_period_ctr #(.NW(NW)) u_ctr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .active_i     (active),
        .n_i          (cur_n),
        .period_end_o (period_end),
        .tick_o       (tick_o),
        .sq_o         (sq_o)
    );

    // R5: the square output is high in every tick cycle
    assert_sq_at_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> sq_o);

    // R10: the modulus in use is never below two
    assert_period_floor_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active |-> (cur_n >= NW'(2)));

endmodule

// File: tb/dmd_clk_div_tb_top.sv
module dmd_clk_div_tb_top;
    localparam int NW = 12;
    localparam int MW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate = 1'b0;
    logic frac = 1'b0;
    logic [NW-1:0] n0 = '0, n1 = '0;
    logic [MW-1:0] m0 = '0, m1 = '0;
    logic tick, sq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dmd_clk_div #(.NW(NW), .MW(MW)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .osc_gate_i  (gate),
        .frac_mode_i (frac),
        .div_lo_i    (n0),
        .div_hi_i    (n1),
        .run_lo_i    (m0),
        .run_hi_i    (m1),
        .tick_o      (tick),
        .sq_o        (sq)
    );

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(int a, int b, int c, int d, bit f);
        n0 = NW'(a); n1 = NW'(b); m0 = MW'(c); m1 = MW'(d); frac = f;
    endtask

    // Called at a falling edge where a tick is seen; returns the period
    // length and the number of cycles with sq high in it
    task automatic next_tick(output int gap, output int hi);
        hi = int'(sq);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (!tick) hi += int'(sq);
        end while (!tick && gap < 5000);
    endtask

    task automatic expect_seq(string req, int exp[$], bit chk_sq);
        foreach (exp[i]) begin
            int g, h;
            next_tick(g, h);
            chk(req, g, exp[i]);
            if (chk_sq) chk("R5 sq high cycles", h, exp[i] / 2);
        end
    endtask

    // Idle the divider, load a configuration, raise the gate, check first tick
    task automatic start(int a, int b, int c, int d, bit f);
        @(negedge clk);
        gate = 1'b0;
        @(negedge clk);
        set_cfg(a, b, c, d, f);
        gate = 1'b1;
        @(negedge clk);
        chk("R2 first tick one cycle after gate", int'(tick), 1);
    endtask

    task automatic t_reset;
        repeat (4) begin
            @(negedge clk);
            chk("R1 tick low in reset", int'(tick), 0);
        end
        chk("R1 sq low in reset", int'(sq), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_gate_off;
        int seen = 0;
        set_cfg(5, 7, 2, 3, 1'b1);
        gate = 1'b0;
        repeat (40) begin
            @(negedge clk);
            seen += int'(tick) + int'(sq);
        end
        chk("R2 no output with gate low", seen, 0);
    endtask

    task automatic t_pattern;
        start(5, 7, 2, 3, 1'b1);
        expect_seq("R3 R4 interleaved periods", '{5, 5, 7, 7, 7, 5, 5, 7, 7, 7}, 1'b1);
    endtask

    task automatic t_mid_change;
        start(5, 7, 2, 3, 1'b1);
        set_cfg(3, 9, 1, 1, 1'b1);
        expect_seq("R6 change waits for pattern end", '{5, 5, 7, 7, 7, 3, 9, 3, 9}, 1'b0);
    endtask

    task automatic t_skip;
        start(5, 6, 0, 2, 1'b1);
        expect_seq("R7 empty low phase skipped", '{6, 6, 6}, 1'b0);
        start(4, 6, 3, 0, 1'b1);
        expect_seq("R7 empty high phase skipped", '{4, 4, 4, 4}, 1'b0);
    endtask

    task automatic t_both_zero;
        int seen = 0;
        @(negedge clk);
        gate = 1'b0;
        @(negedge clk);
        set_cfg(4, 6, 0, 0, 1'b1);
        gate = 1'b1;
        repeat (50) begin
            @(negedge clk);
            seen += int'(tick) + int'(sq);
        end
        chk("R8 idle with both run lengths zero", seen, 0);
        m0 = MW'(1);
        @(negedge clk);
        chk("R8 start when run length set", int'(tick), 1);
        expect_seq("R8 periods after start", '{4, 4}, 1'b0);
    endtask

    task automatic t_integer;
        start(6, 9, 2, 3, 1'b0);
        expect_seq("R9 integer mode periods", '{6, 6, 6, 6, 6, 6}, 1'b0);
        start(5, 9, 0, 0, 1'b0);
        expect_seq("R9 integer mode ignores zero runs", '{5, 5}, 1'b0);
    endtask

    task automatic t_clamp;
        start(1, 0, 1, 1, 1'b1);
        expect_seq("R10 small moduli clamp to 2", '{2, 2, 2}, 1'b1);
    endtask

    task automatic t_gate_drop;
        int seen = 0;
        start(5, 7, 2, 3, 1'b1);
        expect_seq("R11 run before drop", '{5, 5, 7}, 1'b0);
        @(negedge clk);
        gate = 1'b0;
        @(negedge clk);
        chk("R11 tick stops after drop", int'(tick), 0);
        chk("R11 sq stops after drop", int'(sq), 0);
        repeat (20) begin
            @(negedge clk);
            seen += int'(tick) + int'(sq);
        end
        chk("R11 silent while gate low", seen, 0);
        gate = 1'b1;
        @(negedge clk);
        chk("R11 restart tick", int'(tick), 1);
        expect_seq("R11 restart at pattern start", '{5, 5, 7, 7, 7}, 1'b0);
    endtask

    task automatic t_default;
        start(733, 732, 2, 3, 1'b1);
        expect_seq("R4 default 32768 Hz pattern", '{733, 733, 732, 732, 732}, 1'b1);
    endtask

    initial begin
        t_reset();
        t_gate_off();
        t_pattern();
        t_mid_change();
        t_skip();
        t_both_zero();
        t_integer();
        t_clamp();
        t_gate_drop();
        t_default();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #3000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule